// File: doc/BRIEF.md
# 32-bit Integer Execute Unit

This block is the combinational execute stage of a 32-bit integer pipeline with fixed-width instructions. Each transfer carries a raw 32-bit instruction word and the two register operands read for it, `rs_val` and `rt_val`. The unit decodes the opcode and function fields and picks its second operand. That operand is either the `rt_val` register value or the 16-bit immediate, extended in the way the operation calls for. The unit then computes the 32-bit write-back value and the 5-bit destination register index. Arithmetic never traps: results wrap modulo 2^32.

The supported operations are:
- register-register add, subtract, OR, XOR and NOR;
- left and right shifts by a constant amount taken from the instruction;
- add with a sign-extended immediate;
- AND and OR with a zero-extended immediate;
- a load of the immediate into the upper half of the word.

Every other encoding is reported on `illegal` and never writes.

The unit has no storage, so the stream interface is a pure pass-through. `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`, in the same cycle. A transfer completes on a clock edge where both valid and ready are high. The payload outputs depend only on the current input payload. Back-pressure therefore reaches the upstream stage combinationally and costs no cycle. Upstream must hold the payload stable while `in_valid` is high and `in_ready` is low.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode instr[31:26]=0x00, function instr[5:0]=0x21 gives rs_val+rt_val and 0x23 gives rs_val-rt_val, both modulo 2^32 with no overflow indication.
- R2: With opcode 0x00, function 0x25 gives rs_val|rt_val, 0x26 gives rs_val^rt_val and 0x27 gives ~(rs_val|rt_val).
- R3: With opcode 0x00, rt_val is shifted by instr[10:6]. Function 0x00 shifts left with zero fill, 0x02 shifts right with zero fill, and 0x03 shifts right filling with rt_val[31]. A shift amount of 0 returns rt_val unchanged.
- R4: Opcode 0x09 gives rs_val plus instr[15:0] sign-extended to 32 bits, modulo 2^32. An immediate of 0xFFFF therefore adds -1.
- R5: Opcode 0x0C gives rs_val AND the zero-extended immediate. Opcode 0x0D gives rs_val OR the zero-extended immediate.
- R6: Opcode 0x0F gives {instr[15:0], 16'h0000}, whatever the value of rs_val.
- R7: dest is instr[15:11] for opcode 0x00 and instr[20:16] for the immediate opcodes 0x09, 0x0C, 0x0D and 0x0F.
- R8: Any other opcode, or opcode 0x00 with a function other than 0x00, 0x02, 0x03, 0x21, 0x23, 0x25, 0x26 or 0x27, drives illegal=1, wr_en=0, result=0 and dest=0.
- R9: wr_en=1 exactly when in_valid=1, the encoding is legal and dest is not 0.
- R10: out_valid equals in_valid and in_ready equals out_ready in the same cycle. With in_valid=0, wr_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Upstream offers an instruction and its operands |
| in_ready | output | 1 | Unit accepts the offer (follows out_ready) |
| instr | input | 32 | Raw instruction word |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| out_valid | output | 1 | Result is on offer downstream |
| out_ready | input | 1 | Downstream accepts the result |
| result | output | 32 | Value to write back |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Write-back is required |
| illegal | output | 1 | Encoding not supported |

## Verification
The cases that are hardest to reach from the ports are the corners of the arithmetic right shift. Sign fill must appear for every shift amount, and at amount 0 the operand must come through untouched. A random instruction stream rarely pairs a negative operand with each amount. The bench therefore sweeps all 32 shift amounts for all three shift functions, using operands with the top bit set and clear. It also sweeps all 64 opcodes and all 64 function codes against operand pairs that force carries, borrows and wrap-around.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN    = 32;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int SHAMT_W = 5;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h09;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OPC_UPPER = 6'h0F;

  localparam logic [FN_W-1:0] FN_SHL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SHRL = 6'h02;
  localparam logic [FN_W-1:0] FN_SHRA = 6'h03;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h23;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FN_W-1:0] FN_NOR  = 6'h27;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_OR, K_XOR, K_NOR, K_AND, K_SHL, K_SHRL, K_SHRA, K_PASSB
  } kind_e;

  typedef enum logic [1:0] {
    B_REG, B_SIGNED, B_UNSIGNED, B_HIGH
  } bsel_e;

  typedef struct packed {
    logic  legal;
    kind_e kind;
    bsel_e bsel;
    logic  dst_in_rd;
  } ctrl_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
  import exu_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output ctrl_t             ctrl,
  output logic [REG_AW-1:0] dest_idx
);
  logic [OPC_W-1:0] opc;
  logic [FN_W-1:0]  fn;

  assign opc = instr[31:26];
  assign fn  = instr[FN_W-1:0];

  always_comb begin
    ctrl           = '0;
    ctrl.kind      = K_PASSB;
    ctrl.bsel      = B_REG;
    ctrl.dst_in_rd = 1'b0;
    unique case (opc)
      OPC_REG: begin
        ctrl.legal     = 1'b1;
        ctrl.dst_in_rd = 1'b1;
        case (fn)
          FN_ADD:  ctrl.kind = K_ADD;
          FN_SUB:  ctrl.kind = K_SUB;
          FN_OR:   ctrl.kind = K_OR;
          FN_XOR:  ctrl.kind = K_XOR;
          FN_NOR:  ctrl.kind = K_NOR;
          FN_SHL:  ctrl.kind = K_SHL;
          FN_SHRL: ctrl.kind = K_SHRL;
          FN_SHRA: ctrl.kind = K_SHRA;
          default: ctrl.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        ctrl.legal = 1'b1;
        ctrl.kind  = K_ADD;
        ctrl.bsel  = B_SIGNED;
      end
      OPC_ANDI: begin
        ctrl.legal = 1'b1;
        ctrl.kind  = K_AND;
        ctrl.bsel  = B_UNSIGNED;
      end
      OPC_ORI: begin
        ctrl.legal = 1'b1;
        ctrl.kind  = K_OR;
        ctrl.bsel  = B_UNSIGNED;
      end
      OPC_UPPER: begin
        ctrl.legal = 1'b1;
        ctrl.kind  = K_PASSB;
        ctrl.bsel  = B_HIGH;
      end
      default: ctrl.legal = 1'b0;
    endcase
  end

  always_comb begin
    if (!ctrl.legal)       dest_idx = '0;
    else if (ctrl.dst_in_rd) dest_idx = instr[15:11];
    else                   dest_idx = instr[20:16];
  end
endmodule

// File: rtl/exu_operand.sv
module exu_operand
  import exu_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int IW = IMM_W
) (
  input  bsel_e         bsel,
  input  logic [W-1:0]  reg_b,
  input  logic [IW-1:0] imm,
  output logic [W-1:0]  op_b
);
  localparam int PAD = W - IW;

  logic [W-1:0] imm_s, imm_z, imm_h;

  assign imm_s = {{PAD{imm[IW-1]}}, imm};
  assign imm_z = {{PAD{1'b0}}, imm};

  generate
    if (PAD >= IW) begin : g_high_pad
      assign imm_h = {imm, {(W-IW){1'b0}}};
    end else begin : g_high_cut
      assign imm_h = W'({imm, {PAD{1'b0}}});
    end
  endgenerate

  always_comb begin
    unique case (bsel)
      B_SIGNED:   op_b = imm_s;
      B_UNSIGNED: op_b = imm_z;
      B_HIGH:     op_b = imm_h;
      default:    op_b = reg_b;
    endcase
  end
endmodule

// File: rtl/exu_shifter.sv
module exu_shifter #(
  parameter int W      = 32,
  parameter bit BARREL = 1'b1,
  localparam int SW    = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          to_left,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [W-1:0] lres, rres;

  generate
    if (BARREL) begin : g_barrel
      always_comb begin
        lres = din;
        rres = din;
        for (int k = 0; k < SW; k++) begin
          if (amt[k]) begin
            lres = lres << (1 << k);
            if (arith) rres = W'($signed(rres) >>> (1 << k));
            else       rres = rres >> (1 << k);
          end
        end
      end
    end else begin : g_direct
      always_comb begin
        lres = din << amt;
        if (arith) rres = W'($signed(din) >>> amt);
        else       rres = din >> amt;
      end
    end
  endgenerate

  assign dout = to_left ? lres : rres;
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int W       = XLEN,
  parameter int SW      = SHAMT_W,
  parameter bit BARREL  = 1'b1
) (
  input  kind_e         kind,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  sh_src,
  input  logic [SW-1:0] sh_amt,
  output logic [W-1:0]  res
);
  logic [W-1:0] sum, diff, shout;
  logic         is_left, is_arith;

  assign sum      = op_a + op_b;
  assign diff     = op_a - op_b;
  assign is_left  = (kind == K_SHL);
  assign is_arith = (kind == K_SHRA);

  exu_shifter #(.W(W), .BARREL(BARREL)) u_shift (
    .din    (sh_src),
    .amt    (sh_amt),
    .to_left(is_left),
    .arith  (is_arith),
    .dout   (shout)
  );

  always_comb begin
    unique case (kind)
      K_ADD:                res = sum;
      K_SUB:                res = diff;
      K_OR:                 res = op_a | op_b;
      K_XOR:                res = op_a ^ op_b;
      K_NOR:                res = ~(op_a | op_b);
      K_AND:                res = op_a & op_b;
      K_SHL, K_SHRL, K_SHRA: res = shout;
      default:              res = op_b;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter bit BARREL_SHIFT = 1'b1
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   result,
  output logic [REG_AW-1:0] dest,
  output logic              wr_en,
  output logic              illegal
);
  ctrl_t             ctrl;
  logic [REG_AW-1:0] dest_idx;
  logic [XLEN-1:0]   op_b;
  logic [XLEN-1:0]   alu_res;

  exu_decode u_dec (
    .instr   (instr),
    .ctrl    (ctrl),
    .dest_idx(dest_idx)
  );

  exu_operand #(.W(XLEN), .IW(IMM_W)) u_opnd (
    .bsel (ctrl.bsel),
    .reg_b(rt_val),
    .imm  (instr[IMM_W-1:0]),
    .op_b (op_b)
  );

  exu_alu #(.W(XLEN), .SW(SHAMT_W), .BARREL(BARREL_SHIFT)) u_alu (
    .kind  (ctrl.kind),
    .op_a  (rs_val),
    .op_b  (op_b),
    .sh_src(rt_val),
    .sh_amt(instr[10:6]),
    .res   (alu_res)
  );

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign illegal   = ~ctrl.legal;
  assign result    = ctrl.legal ? alu_res : '0;
  assign dest      = dest_idx;
  assign wr_en     = in_valid & ctrl.legal & (dest_idx != '0);
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk
  import exu_pkg::*;
(
  input logic              in_valid,
  input logic              in_ready,
  input logic [XLEN-1:0]   instr,
  input logic [XLEN-1:0]   rs_val,
  input logic [XLEN-1:0]   rt_val,
  input logic              out_valid,
  input logic              out_ready,
  input logic [XLEN-1:0]   result,
  input logic [REG_AW-1:0] dest,
  input logic              wr_en,
  input logic              illegal
);
  always_comb begin
    // R8: an unsupported encoding never writes and drives a zero result
    a_r8_illegal_quiet: assert (!illegal || (!wr_en && result == '0 && dest == '0))
      else $error("illegal encoding produced a write or a value");
    // R9: register 0 is never written
    a_r9_no_zero_write: assert (!wr_en || dest != '0)
      else $error("write enabled with destination 0");
    // R10: nothing writes without an offered transfer
    a_r10_idle_no_write: assert (in_valid || !wr_en)
      else $error("write enabled while idle");
    // R6: upper-half load leaves the low half clear and copies the immediate
    a_r6_upper_load: assert (instr[31:26] != OPC_UPPER ||
                             result == {instr[15:0], 16'h0000})
      else $error("upper load value wrong");
    // R3: zero shift amount passes the operand through
    a_r3_zero_shift: assert (!(instr[31:26] == OPC_REG && instr[10:6] == 5'd0 &&
                               (instr[5:0] == FN_SHL || instr[5:0] == FN_SHRL ||
                                instr[5:0] == FN_SHRA)) || result == rt_val)
      else $error("zero shift altered operand");
    // R7: immediate forms write the register named in bits 20:16
    a_r7_imm_dest: assert (illegal || instr[31:26] == OPC_REG || dest == instr[20:16])
      else $error("immediate form destination wrong");
  end
endmodule

bind int_exec_unit int_exec_unit_chk u_chk (.*);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid, in_ready, out_valid, out_ready, wr_en, illegal;
  logic [31:0] instr, rs_val, rt_val, result;
  logic [4:0]  dest;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  always #10 clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .in_valid(in_valid), .in_ready(in_ready), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .dest(dest),
    .wr_en(wr_en), .illegal(illegal)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <100000", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: instr=%h actual=%h expected=%h", tag, instr, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [4:0] d, output logic leg,
                       output string tag);
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  sh;
    logic [31:0] sx, zx;
    op = ins[31:26]; fn = ins[5:0]; sh = ins[10:6];
    sx = {{16{ins[15]}}, ins[15:0]};
    zx = {16'h0, ins[15:0]};
    leg = 1'b1; r = 32'h0; d = ins[20:16]; tag = "R8";
    if (op == 6'h00) begin
      d = ins[15:11];
      case (fn)
        6'h21: begin r = a + b; tag = "R1"; end
        6'h23: begin r = a - b; tag = "R1"; end
        6'h25: begin r = a | b; tag = "R2"; end
        6'h26: begin r = a ^ b; tag = "R2"; end
        6'h27: begin r = ~(a | b); tag = "R2"; end
        6'h00: begin r = b << sh; tag = "R3"; end
        6'h02: begin r = b >> sh; tag = "R3"; end
        6'h03: begin
          r = b;
          for (int i = 0; i < 32; i++) if (i < sh) r = {b[31], r[31:1]};
          tag = "R3";
        end
        default: leg = 1'b0;
      endcase
    end else if (op == 6'h09) begin r = a + sx; tag = "R4"; end
    else if (op == 6'h0C) begin r = a & zx; tag = "R5"; end
    else if (op == 6'h0D) begin r = a | zx; tag = "R5"; end
    else if (op == 6'h0F) begin r = ins[15:0] * 32'h10000; tag = "R6"; end
    else leg = 1'b0;
    if (!leg) begin r = 32'h0; d = 5'd0; tag = "R8"; end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic v);
    logic [31:0] er;
    logic [4:0]  ed;
    logic        el;
    string       tg;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b; in_valid = v;
    #5;
    model(ins, a, b, er, ed, el, tg);
    chk(tg, result, er);
    chk(el ? "R7 dest" : "R8 dest", {27'h0, dest}, {27'h0, ed});
    chk("R8 illegal", {31'h0, illegal}, {31'h0, ~el});
    chk("R9 wr_en", {31'h0, wr_en}, {31'h0, v & el & (ed != 5'd0)});
    chk("R10 out_valid", {31'h0, out_valid}, {31'h0, v});
  endtask

  logic [31:0] av [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678};
  logic [31:0] bv [4] = '{32'h0000_0001, 32'h0000_0001, 32'h7FFF_FFFF, 32'h9ABC_DEF0};

  initial begin
    in_valid = 1'b0; out_ready = 1'b0; instr = 32'h0; rs_val = 32'h0; rt_val = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle out_valid", {31'h0, out_valid}, 32'h0);
    chk("R10 idle wr_en", {31'h0, wr_en}, 32'h0);
    chk("R10 in_ready low", {31'h0, in_ready}, 32'h0);
    out_ready = 1'b1; #1;
    chk("R10 in_ready follows", {31'h0, in_ready}, 32'h1);

    // every opcode, immediate forms (R4 R5 R6 R7 R8)
    for (int op = 1; op < 64; op++)
      for (int p = 0; p < 4; p++)
        apply({op[5:0], 5'(p * 7 + 3), 5'(op + p), 16'(bv[p] ^ 32'hA5F0 + op)}, av[p], bv[p], 1'b1);

    // every function code in register form (R1 R2 R3 R8)
    for (int fn = 0; fn < 64; fn++)
      for (int p = 0; p < 4; p++)
        apply({6'h00, 5'd4, 5'd9, 5'(fn + p), 5'(p * 5), fn[5:0]}, av[p], bv[p], 1'b1);

    // all shift amounts with sign bit set and clear (R3)
    for (int s = 0; s < 32; s++) begin
      apply({6'h00, 5'd0, 5'd2, 5'd7, s[4:0], 6'h00}, 32'h0, 32'hF00F_8001, 1'b1);
      apply({6'h00, 5'd0, 5'd2, 5'd7, s[4:0], 6'h02}, 32'h0, 32'hF00F_8001, 1'b1);
      apply({6'h00, 5'd0, 5'd2, 5'd7, s[4:0], 6'h03}, 32'h0, 32'hF00F_8001, 1'b1);
      apply({6'h00, 5'd0, 5'd2, 5'd7, s[4:0], 6'h03}, 32'h0, 32'h700F_8001, 1'b1);
    end

    // add-immediate boundary values (R4)
    apply({6'h09, 5'd1, 5'd5, 16'hFFFF}, 32'h0000_0005, 32'h0, 1'b1);
    chk("R4 minus one", result, 32'h0000_0004);
    apply({6'h09, 5'd1, 5'd5, 16'h8000}, 32'h0000_0000, 32'h0, 1'b1);
    apply({6'h09, 5'd1, 5'd5, 16'h7FFF}, 32'hFFFF_FFFF, 32'h0, 1'b1);
    apply({6'h09, 5'd1, 5'd5, 16'h0001}, 32'hFFFF_FFFF, 32'h0, 1'b1);
    chk("R4 wrap", result, 32'h0000_0000);

    // upper load then OR of the low half (R6 R5)
    apply({6'h0F, 5'd3, 5'd5, 16'hDEAD}, 32'h1111_1111, 32'h0, 1'b1);
    chk("R6 upper ignores rs", result, 32'hDEAD_0000);
    apply({6'h0D, 5'd5, 5'd5, 16'hBEEF}, 32'hDEAD_0000, 32'h0, 1'b1);
    chk("R5 combine", result, 32'hDEAD_BEEF);

    // subtract wrap and destination 0 (R1 R9)
    apply({6'h00, 5'd1, 5'd2, 5'd0, 5'd0, 6'h23}, 32'h0, 32'h1, 1'b1);
    chk("R1 borrow wrap", result, 32'hFFFF_FFFF);
    chk("R9 dest zero", {31'h0, wr_en}, 32'h0);

    // idle transfers never write (R10 R9)
    apply({6'h00, 5'd1, 5'd2, 5'd3, 5'd0, 6'h21}, 32'h1, 32'h2, 1'b0);
    apply({6'h09, 5'd1, 5'd6, 16'h0010}, 32'h1, 32'h2, 1'b0);
    out_ready = 1'b0; #1;
    chk("R10 back-pressure", {31'h0, in_ready}, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule